// File: doc/BRIEF.md
# Hybrid Lookahead-Ripple Carry-Select Adder

This block adds two 64-bit operands and a carry-in, and returns a 64-bit sum and a carry-out. It is a carry-select chain. The lowest stage is a single 4-bit lookahead group driven by the real carry-in. Each later stage is built twice, once assuming an incoming carry of 0 and once assuming 1. A multiplexer then picks one copy using the true carry from the stage below.

Inside each duplicated stage, a flat 4-bit lookahead group forms the stage's low bits. Its carry then feeds a ripple tail. The tail is 1 bit long in the first duplicated stage and grows by one bit per stage, so the middle stages are 5, 6, 7, 8, 9, 10 and 11 bits wide. A last 4-bit lookahead-only stage covers bits 60 to 63. Because the stages widen, the chain needs eight selection multiplexer levels, where a uniform 4-bit grouping would need fifteen.

Stage boundaries are derived from parameters. A parameter can add one register stage on the outputs. That register stage is on by default and uses an active-low asynchronous reset.

Top module: `hcsa_adder64`

## Requirements
- R1: `{cout, sum}` equals the 65-bit value `a + b + cin` for any operands.
- R2: `cout` is bit 64 of `a + b + cin`; it is 1 exactly when the unsigned sum overflows 64 bits.
- R3: With the output register enabled (default), `sum` and `cout` reflect the inputs sampled at the previous rising clock edge. Between edges the outputs do not follow input changes.
- R4: While `rst_n` is 0, `sum` is all zeros and `cout` is 0, whatever the operands are.
- R5: Stage boundaries sit at bit positions 4, 9, 15, 22, 30, 39, 49 and 60. A carry generated anywhere below a boundary reaches the bits above it correctly. For example, `a = 2^p - 1`, `b = 0`, `cin = 1` yields `sum = 2^p` for each boundary `p`.
- R6: All-ones operands with `cin = 1` give an all-ones sum and `cout = 1`. A full-length carry chain (`a` all ones, `b = 0`, `cin = 1`) gives sum 0 and `cout = 1`.
- R7: Alternating patterns add correctly: `a = 0xAAAA...AAAA` with `b = 0x5555...5555` gives all ones with `cin = 0`, and zero with `cout = 1` with `cin = 1`.
- R8: With both operands zero, `sum` equals `cin` in bit 0 and `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| a | input | 64 | First operand |
| b | input | 64 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 64 | Sum bits |
| cout | output | 1 | Carry out of bit 63 |

## Verification
A wrong selection at any stage boundary shows up at the ports as a sum that is off by exactly `2^p`, where `p` is the bit position of the bad boundary. Such an error also propagates into every higher stage's choice and possibly into `cout`. With the default output register, this appears on the very next clock edge after the offending operands are applied. The stimulus therefore forces carries to be generated just below each boundary and to ripple across the whole width, so that every multiplexer level is exercised in both states.

// File: rtl/hcsa_pkg.sv
`timescale 1ns/1ps
package hcsa_pkg;

  // Width of duplicated stage k (k = 0 is the first stage after the low group).
  function automatic int sel_width(int grp, int tail0, int k);
    return grp + tail0 + k;
  endfunction

  // Lowest bit position of duplicated stage k.
  function automatic int sel_base(int grp, int tail0, int k);
    return grp + k * (grp + tail0) + (k * (k - 1)) / 2;
  endfunction

  // Total bits covered by low group, nsel growing stages and final group.
  function automatic int chain_width(int grp, int tail0, int nsel);
    return sel_base(grp, tail0, nsel) + grp;
  endfunction

  // Exclusive upper bit position of stage i (0 = low group, nsel+1 = final).
  function automatic int stage_top(int grp, int tail0, int nsel, int i);
    if (i == 0) return grp;
    if (i <= nsel) return sel_base(grp, tail0, i - 1) + sel_width(grp, tail0, i - 1);
    return chain_width(grp, tail0, nsel);
  endfunction

endpackage

// File: rtl/hcsa_cla.sv
`timescale 1ns/1ps
// Flat lookahead group: each carry is a sum of products of generate,
// propagate and the group carry-in, with no rippling between bits.
module hcsa_cla #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W-1:0] gen;
  logic [W-1:0] prp;
  logic [W:0]   cy;

  assign gen = a & b;
  assign prp = a ^ b;

  always_comb begin
    logic acc;
    logic term;
    cy[0] = ci;
    for (int i = 0; i < W; i++) begin
      acc = ci;
      for (int k = 0; k <= i; k++) acc = acc & prp[k];
      for (int j = 0; j <= i; j++) begin
        term = gen[j];
        for (int k = j + 1; k <= i; k++) term = term & prp[k];
        acc = acc | term;
      end
      cy[i+1] = acc;
    end
  end

  assign s  = prp ^ cy[W-1:0];
  assign co = cy[W];
endmodule

// File: rtl/hcsa_ripple.sv
`timescale 1ns/1ps
// Ripple tail of full adders.
module hcsa_ripple #(
  parameter int W = 1
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] cy;
  assign cy[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_fa
    assign s[i]    = a[i] ^ b[i] ^ cy[i];
    assign cy[i+1] = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
  end

  assign co = cy[W];
endmodule

// File: rtl/hcsa_select_stage.sv
`timescale 1ns/1ps
// One carry-select stage: lookahead group plus optional ripple tail, built
// for both assumed carries, then chosen by the real incoming carry.
module hcsa_select_stage #(
  parameter int GRP  = 4,
  parameter int TAIL = 1,
  localparam int SW  = GRP + TAIL
) (
  input  logic [SW-1:0] a,
  input  logic [SW-1:0] b,
  input  logic          ci,
  output logic [SW-1:0] s,
  output logic          co
);
  for (genvar v = 0; v < 2; v++) begin : g_cand
    logic [SW-1:0] cs;
    logic          cc;
    logic          grp_co;

    hcsa_cla #(.W(GRP)) u_cla (
      .a  (a[GRP-1:0]),
      .b  (b[GRP-1:0]),
      .ci (1'(v)),
      .s  (cs[GRP-1:0]),
      .co (grp_co)
    );

    if (TAIL > 0) begin : g_tail
      hcsa_ripple #(.W(TAIL)) u_rip (
        .a  (a[SW-1:GRP]),
        .b  (b[SW-1:GRP]),
        .ci (grp_co),
        .s  (cs[SW-1:GRP]),
        .co (cc)
      );
    end else begin : g_notail
      assign cc = grp_co;
    end
  end

  assign s  = ci ? g_cand[1].cs : g_cand[0].cs;
  assign co = ci ? g_cand[1].cc : g_cand[0].cc;
endmodule

// File: rtl/hcsa_adder64.sv
`timescale 1ns/1ps
module hcsa_adder64
  import hcsa_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter int GRP     = 4,
  parameter int TAIL0   = 1,
  parameter int NSEL    = 7,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             cin,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int NSTG    = NSEL + 2;
  localparam int TOP_LO  = sel_base(GRP, TAIL0, NSEL);

  logic [NSTG-1:0]  stage_co;
  logic [WIDTH-1:0] sum_c;

  // Lowest group: real carry-in, no duplication.
  hcsa_cla #(.W(GRP)) u_low (
    .a  (a[GRP-1:0]),
    .b  (b[GRP-1:0]),
    .ci (cin),
    .s  (sum_c[GRP-1:0]),
    .co (stage_co[0])
  );

  // Growing stages: lookahead group plus a tail one bit longer each time.
  for (genvar k = 0; k < NSEL; k++) begin : g_sel
    localparam int LO = sel_base(GRP, TAIL0, k);
    localparam int SW = sel_width(GRP, TAIL0, k);
    hcsa_select_stage #(.GRP(GRP), .TAIL(TAIL0 + k)) u_stage (
      .a  (a[LO +: SW]),
      .b  (b[LO +: SW]),
      .ci (stage_co[k]),
      .s  (sum_c[LO +: SW]),
      .co (stage_co[k+1])
    );
  end

  // Final group: lookahead only, selected by the chain carry.
  hcsa_select_stage #(.GRP(GRP), .TAIL(0)) u_top (
    .a  (a[TOP_LO +: GRP]),
    .b  (b[TOP_LO +: GRP]),
    .ci (stage_co[NSEL]),
    .s  (sum_c[TOP_LO +: GRP]),
    .co (stage_co[NSEL+1])
  );

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sum  <= '0;
        cout <= 1'b0;
      end else begin
        sum  <= sum_c;
        cout <= stage_co[NSTG-1];
      end
    end
  end else begin : g_comb
    assign sum  = sum_c;
    assign cout = stage_co[NSTG-1];
  end
endmodule

// File: rtl/hcsa_adder64_chk.sv
`timescale 1ns/1ps
module hcsa_adder64_chk
  import hcsa_pkg::*;
#(
  parameter int WIDTH   = 64,
  parameter int GRP     = 4,
  parameter int TAIL0   = 1,
  parameter int NSEL    = 7,
  parameter bit OUT_REG = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] a,
  input logic [WIDTH-1:0] b,
  input logic             cin,
  input logic [WIDTH-1:0] sum,
  input logic             cout,
  input logic [NSEL+1:0]  stage_co
);
  logic [WIDTH:0] ref_now;
  assign ref_now = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};

  // R5
  initial begin
    width_sum_chk: assert (chain_width(GRP, TAIL0, NSEL) == WIDTH)
      else $error("stage widths do not cover the operand width");
  end

  // R5
  for (genvar i = 0; i <= NSEL; i++) begin : g_bnd
    localparam int P = stage_top(GRP, TAIL0, NSEL, i);
    localparam logic [WIDTH-1:0] MASK = {WIDTH{1'b1}} >> (WIDTH - P);
    logic [WIDTH:0] part;
    assign part = {1'b0, a & MASK} + {1'b0, b & MASK} + {{WIDTH{1'b0}}, cin};
    bnd_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_co[i] == part[P]);
  end

  if (OUT_REG) begin : g_reg
    // R1
    sum_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> {cout, sum} == $past(ref_now));
    // R2
    cout_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> cout == $past(ref_now[WIDTH]));
    // R8
    cin_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(a) == '0 && $past(b) == '0)
      |-> (sum == WIDTH'($past(cin)) && !cout));
    // R4
    rst_out_chk: assert property (@(negedge clk)
      !rst_n |-> (sum == '0 && !cout));
  end else begin : g_comb
    // R1
    sum_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
      {cout, sum} == ref_now);
  end
endmodule

bind hcsa_adder64 hcsa_adder64_chk #(
  .WIDTH(WIDTH), .GRP(GRP), .TAIL0(TAIL0), .NSEL(NSEL), .OUT_REG(OUT_REG)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .a        (a),
  .b        (b),
  .cin      (cin),
  .sum      (sum),
  .cout     (cout),
  .stage_co (stage_co)
);

// File: tb/test_hcsa_adder64.sv
`timescale 1ns/1ps
module test_hcsa_adder64;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        cin = 1'b0;
  logic [63:0] sum;
  logic        cout;

  int checks = 0;
  int failures = 0;
  logic [64:0] exp_q[$];
  logic [64:0] last_out;

  always #2.5 clk = ~clk;

  hcsa_adder64 i_hcsa_adder64 (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
  );

  task automatic check(input bit ok, input string tag, input logic [64:0] got, input logic [64:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Apply one operand set at a falling edge; compare one clock later.
  task automatic step(input logic [63:0] xa, input logic [63:0] xb, input logic xc, input string tag);
    logic [64:0] e;
    a = xa; b = xb; cin = xc;
    exp_q.push_back({1'b0, xa} + {1'b0, xb} + 65'(xc));
    #1;
    check({cout, sum} == last_out, "R3 hold", {cout, sum}, last_out);
    @(negedge clk);
    e = exp_q.pop_front();
    check(sum == e[63:0], tag, {1'b0, sum}, {1'b0, e[63:0]});
    check(cout == e[64], "R2", {64'b0, cout}, {64'b0, e[64]});
    last_out = {cout, sum};
  endtask

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int bnd[8] = '{4, 9, 15, 22, 30, 39, 49, 60};
    logic [63:0] m;
    a = 64'hFFFF_0000_1234_5678; b = 64'h0F0F_F0F0_AAAA_5555; cin = 1'b1;
    repeat (3) @(negedge clk);
    check({cout, sum} == 65'b0, "R4 reset", {cout, sum}, 65'b0);
    rst_n = 1'b1;
    last_out = 65'b0;

    step(64'h0, 64'h0, 1'b0, "R8 zero");
    step(64'h0, 64'h0, 1'b1, "R8 cin");
    step('1, '1, 1'b1, "R6 ones");
    step('1, 64'h0, 1'b1, "R6 full chain");
    step(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b0, "R7 alt");
    step(64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 1'b1, "R7 alt cin");
    step(64'h5555_5555_5555_5555, 64'h5555_5555_5555_5555, 1'b0, "R7 alt same");

    foreach (bnd[i]) begin
      m = (64'd1 << bnd[i]) - 64'd1;
      step(m, 64'h0, 1'b1, "R5 boundary cin");
      step(64'h1, m, 1'b0, "R5 boundary gen");
      step(m, m, 1'b0, "R5 boundary double");
    end

    for (int i = 0; i < 200; i++) begin
      step({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule